// File: doc/BRIEF.md
# Active Burst Mode Controller

This block is the light-load supervisor of a switching power controller. It watches four digital comparator results taken from the feedback node. From them it decides whether the converter runs in normal mode or in a low-power burst mode. During a burst it runs the converter in bursts of switching with rest periods between them.

Normal mode lasts until feedback stays below the burst-entry threshold for a blanking window of `HOLD_CYCLES` clocks. The block then raises a burst flag and turns the internal bias off. While the flag is set, the bias and switching turn on when feedback rises above the upper burst level (3.5 V). They turn off again when feedback falls below the lower burst level (3.2 V), so feedback ramps up and down between the two levels. A feedback level above 4.0 V ends the burst at once and restores the full current limit. A disable input keeps the block out of burst mode.

Top module: `burst_mode_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, the burst flag and the reduced-limit select are 0, and bias enable and switch enable are 1.
- R2: In normal mode, entry to burst mode happens at the clock edge that samples `fb_low_i`=1 with `burst_dis_i`=0 for the `HOLD_CYCLES`-th edge in a row. The outputs change right after that edge and not earlier.
- R3: Any edge in normal mode that samples `fb_low_i`=0 restarts the blanking count from zero. The next entry then needs a new, complete run of `HOLD_CYCLES` edges.
- R4: An edge that samples `burst_disable_i`=1 in normal mode never enters burst and restarts the blanking count, whatever `fb_low_i` is.
- R5: At entry the burst flag becomes 1 and bias enable and switch enable become 0.
- R6: In burst with bias off, an edge that samples `fb_wake_i`=1 turns bias enable and switch enable on. The burst flag stays 1.
- R7: The reduced-limit select equals the burst flag. Switch enable always equals bias enable.
- R8: In burst with bias on, an edge that samples `fb_sleep_i`=1 turns bias enable and switch enable off. The burst flag stays 1.
- R9: In burst, an edge that samples `fb_exit_i`=1 returns the block to normal mode (flag 0, bias 1, switch 1, reduced-limit 0) from either the rest or the switching phase. This takes priority over wake and sleep.
- R10: In normal mode, `fb_wake_i`, `fb_sleep_i` and `fb_exit_i` have no effect on any output.
- R11: In burst mode, `fb_low_i` and `burst_dis_i` have no effect on any output. Only `fb_exit_i` ends the burst.
- R12: After a burst ends, a new entry needs a complete fresh run of `HOLD_CYCLES` qualifying edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_low_i | input | 1 | Feedback below the burst-entry threshold |
| fb_wake_i | input | 1 | Feedback above the upper burst level (3.5 V) |
| fb_sleep_i | input | 1 | Feedback below the lower burst level (3.2 V) |
| fb_exit_i | input | 1 | Feedback above the burst-exit level (4.0 V) |
| burst_dis_i | input | 1 | Blocks burst entry when 1 |
| burst_o | output | 1 | Burst mode flag |
| bias_en_o | output | 1 | Internal bias enable |
| switch_en_o | output | 1 | Switching enable for the modulator |
| low_ilim_o | output | 1 | Selects the reduced burst current limit |

## Verification
The bench builds the block with `HOLD_CYCLES` set to 12 instead of the one million clocks that a 20 ms window takes at 50 MHz. At that size the exact entry edge, a drop one cycle before expiry, and repeated entry and exit cycles all fit in a few thousand clocks. Random feedback inputs that change only now and then give long qualifying runs. The same short window also lets random exits land in both burst phases.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [1:0] {
        PH_NORMAL = 2'd0,
        PH_REST   = 2'd1,
        PH_PULSE  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } fsm_regs_t;

    typedef struct packed {
        logic burst;
        logic bias;
        logic sw;
        logic low_ilim;
    } out_bus_t;

endpackage

// File: rtl/burst_blank_timer.sv
module burst_blank_timer #(
    parameter int unsigned HOLD_CYCLES = 1000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    output logic expire_o
);
    localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = 1'b0;
        if (arm_i) begin
            if (tmr_q.cnt == LAST) begin
                expire_o  = 1'b1;
                tmr_d.cnt = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + CNT_W'(1);
            end
        end else begin
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/burst_phase_fsm.sv
module burst_phase_fsm
    import burst_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   expire_i,
    input  logic   wake_i,
    input  logic   sleep_i,
    input  logic   exit_i,
    output phase_e phase_o
);
    fsm_regs_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.phase)
            PH_NORMAL: begin
                if (expire_i) fsm_d.phase = PH_REST;
            end
            PH_REST: begin
                if (exit_i)      fsm_d.phase = PH_NORMAL;
                else if (wake_i) fsm_d.phase = PH_PULSE;
            end
            PH_PULSE: begin
                if (exit_i)       fsm_d.phase = PH_NORMAL;
                else if (sleep_i) fsm_d.phase = PH_REST;
            end
            default: fsm_d.phase = PH_NORMAL;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsm_q.phase <= PH_NORMAL;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign phase_o = fsm_q.phase;
endmodule

// File: rtl/burst_out_decode.sv
module burst_out_decode
    import burst_pkg::*;
(
    input  phase_e   phase_i,
    output out_bus_t out_o
);
    always_comb begin
        out_o = '0;
        unique case (phase_i)
            PH_NORMAL: begin
                out_o.bias = 1'b1;
                out_o.sw   = 1'b1;
            end
            PH_REST: begin
                out_o.burst    = 1'b1;
                out_o.low_ilim = 1'b1;
            end
            PH_PULSE: begin
                out_o.burst    = 1'b1;
                out_o.bias     = 1'b1;
                out_o.sw       = 1'b1;
                out_o.low_ilim = 1'b1;
            end
            default: begin
                out_o.bias = 1'b1;
                out_o.sw   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
    import burst_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 1000000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fb_low_i,
    input  logic fb_wake_i,
    input  logic fb_sleep_i,
    input  logic fb_exit_i,
    input  logic burst_dis_i,
    output logic burst_o,
    output logic bias_en_o,
    output logic switch_en_o,
    output logic low_ilim_o
);
    phase_e   phase;
    logic     arm;
    logic     expire;
    out_bus_t outs;

    assign arm = (phase == PH_NORMAL) && fb_low_i && !burst_dis_i;

    burst_blank_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .arm_i   (arm),
        .expire_o(expire)
    );

    burst_phase_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .expire_i(expire),
        .wake_i  (fb_wake_i),
        .sleep_i (fb_sleep_i),
        .exit_i  (fb_exit_i),
        .phase_o (phase)
    );

    burst_out_decode u_dec (
        .phase_i(phase),
        .out_o  (outs)
    );

    assign burst_o     = outs.burst;
    assign bias_en_o   = outs.bias;
    assign switch_en_o = outs.sw;
    assign low_ilim_o  = outs.low_ilim;
endmodule

// File: rtl/burst_mode_ctrl_chk.sv
module burst_mode_ctrl_chk #(
    parameter int unsigned HOLD_CYCLES = 1000000
) (
    input logic clk_i,
    input logic rst_ni,
    input logic fb_low_i,
    input logic fb_wake_i,
    input logic fb_sleep_i,
    input logic fb_exit_i,
    input logic burst_dis_i,
    input logic burst_o,
    input logic bias_en_o,
    input logic switch_en_o,
    input logic low_ilim_o
);
    int unsigned run_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            run_q <= 0;
        end else if (!burst_o && fb_low_i && !burst_dis_i) begin
            if (run_q < HOLD_CYCLES) run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    AST_NORMAL_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !burst_o |-> (bias_en_o && switch_en_o && !low_ilim_o)); // R1
    AST_EARLY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!burst_o && run_q < HOLD_CYCLES - 1) |=> !burst_o); // R2
    AST_DISABLE_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!burst_o && burst_dis_i) |=> !burst_o); // R4
    AST_ENTRY_BIAS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(burst_o) |-> (!bias_en_o && !switch_en_o)); // R5
    AST_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_o && !bias_en_o && fb_wake_i && !fb_exit_i) |=> (burst_o && bias_en_o)); // R6
    AST_LIMIT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (low_ilim_o == burst_o) && (switch_en_o == bias_en_o)); // R7
    AST_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_o && bias_en_o && fb_sleep_i && !fb_exit_i) |=> (burst_o && !bias_en_o)); // R8
    AST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_o && fb_exit_i) |=> !burst_o); // R9
    AST_STAY_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_o && !fb_exit_i) |=> burst_o); // R11
endmodule

bind burst_mode_ctrl burst_mode_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (.*);

// File: tb/burst_mode_ctrl_tb.sv
`timescale 1ns/1ps
module burst_mode_ctrl_tb;
    localparam int unsigned HOLD = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_low = 1'b0, fb_wake = 1'b0, fb_sleep = 1'b0, fb_exit = 1'b0, dis = 1'b0;
    logic burst, bias, sw, low;

    int n_checks = 0;
    int n_fails  = 0;

    logic m_burst = 1'b0;
    logic m_bias  = 1'b1;
    int   m_run   = 0;

    always #10 clk = ~clk;

    burst_mode_ctrl #(.HOLD_CYCLES(HOLD)) u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .fb_low_i(fb_low), .fb_wake_i(fb_wake), .fb_sleep_i(fb_sleep),
        .fb_exit_i(fb_exit), .burst_dis_i(dis),
        .burst_o(burst), .bias_en_o(bias), .switch_en_o(sw), .low_ilim_o(low)
    );

    function automatic string auto_tag(logic be, logic wk, logic sl, logic ex, logic ds);
        if (!m_burst) begin
            if (be && ds)                      return "R4";
            if (be && m_run == int'(HOLD) - 1) return "R2 R5";
            if (wk || sl || ex)                return "R10";
            return "R3";
        end
        if (ex)            return "R9";
        if (!m_bias && wk) return "R6";
        if (m_bias && sl)  return "R8";
        if (be || ds)      return "R11";
        return "R7";
    endfunction

    task automatic model_step(logic be, logic wk, logic sl, logic ex, logic ds);
        if (!m_burst) begin
            if (be && !ds) begin
                if (m_run == int'(HOLD) - 1) begin
                    m_burst = 1'b1; m_bias = 1'b0; m_run = 0;
                end else begin
                    m_run++;
                end
            end else begin
                m_run = 0;
            end
        end else if (ex) begin
            m_burst = 1'b0; m_bias = 1'b1; m_run = 0;
        end else if (!m_bias && wk) begin
            m_bias = 1'b1;
        end else if (m_bias && sl) begin
            m_bias = 1'b0;
        end
    endtask

    task automatic compare(string tag);
        logic [3:0] act, exp;
        act = {burst, bias, sw, low};
        exp = {m_burst, m_bias, m_bias, m_burst};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%b expected=%b (burst,bias,switch,limit)", tag, act, exp);
        end
    endtask

    task automatic step(logic be, logic wk, logic sl, logic ex, logic ds, string tag_in);
        string tag;
        tag = (tag_in == "") ? auto_tag(be, wk, sl, ex, ds) : tag_in;
        fb_low = be; fb_wake = wk; fb_sleep = sl; fb_exit = ex; dis = ds;
        model_step(be, wk, sl, ex, ds);
        @(posedge clk);
        #5;
        compare(tag);
    endtask

    initial begin
        #(200000 * 20);
        n_fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #5;
        compare("R1");
        rst_n = 1'b1;
        @(posedge clk); #5;
        compare("R1");

        // R3: drop one cycle short of expiry
        for (int i = 0; i < int'(HOLD) - 1; i++) step(1, 0, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R3");
        // R2: full run, exact entry edge
        for (int i = 0; i < int'(HOLD); i++) step(1, 0, 0, 0, 0, "");
        // R6 / R8 / R9 with sleep in the same cycle as exit
        step(0, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 0, 0, "R8");
        step(0, 1, 0, 0, 0, "R6");
        step(0, 0, 1, 1, 0, "R9");
        // R12: fresh run after exit
        for (int i = 0; i < int'(HOLD) - 1; i++) step(1, 0, 0, 0, 0, "R12");
        step(1, 0, 0, 0, 0, "R12");
        // R11: low and disable ignored in burst
        for (int i = 0; i < 5; i++) step(i % 2 == 0, 0, 0, 0, 1, "R11");
        // R9: exit from rest phase, with wake present
        step(0, 1, 0, 1, 0, "R9");
        // R10: burst-phase inputs in normal mode
        step(0, 1, 1, 1, 0, "R10");
        // R4: disable holds off entry for a long run
        for (int i = 0; i < 3 * int'(HOLD); i++) step(1, 0, 0, 0, 1, "R4");
        step(1, 0, 0, 0, 0, "R4");

        // random phase
        begin
            logic be, ds;
            be = 1'b0; ds = 1'b0;
            for (int i = 0; i < 5000; i++) begin
                if ($urandom_range(0, 19) == 0) be = ~be;
                if ($urandom_range(0, 39) == 0) ds = ~ds;
                step(be, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                     $urandom_range(0, 59) == 0, ds, "");
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule